// File: doc/BRIEF.md
# SPI Slave-Select Manager

This block owns the active-low slave-select line of an SPI controller that can run as either bus master or slave. Level-style configuration inputs decide whether the select is handled by software or by hardware, which role the controller takes, whether the select pin is driven as an output, and whether the select is released automatically after each transfer. From these the block produces the internal select level, the pin value and its output enable, a transfer-permission signal for the shifter, and a sticky mode-fault flag.

When the controller is a master and another device pulls the shared select line low, the block raises a fault. In the same cycle it drops the master role and the controller enable, so that two masters never drive the bus. In slave role with hardware select, it reports the slave as selected only while the synchronized pin input is low. If the select is withdrawn during a frame, it emits an abort pulse. The optional auto-release mode frames each transfer with guard intervals, so that the rising edge at the end of a transfer can latch external shift registers without software action. The shifter, the serial clock generator and the bus interface sit outside. The block sees them only through request, busy and frame-done handshakes.

Top module: `ssel_ctrl`

## Requirements
- R1: After reset, `run_en`, `is_master`, `sel_pin_oe`, `mode_fault`, `slave_abort` and `xfer_go` are 0 and `sel_pin_o` is 1, even while `xfer_req` is 1.
- R2: With `cfg_sw_sel`=1 (software select), `sel_int` equals `cfg_sw_level`, `sel_pin_oe` is 0 whatever `cfg_drive_en` is, and the pin input is not used.
- R3: With hardware select, master role, `cfg_drive_en`=1, the controller enabled and `cfg_auto_rel`=0, `sel_pin_oe` is 1 and `sel_pin_o` stays 0 across and between transfers. `xfer_go` follows `xfer_req` in the same cycle.
- R4: With hardware select and `cfg_drive_en`=0, `sel_pin_oe` is 0, and `sel_int` reflects the synchronized pin input.
- R5: `sel_pin_i` passes through a two-flop synchronizer. A change is seen by selection logic after the second rising clock edge.
- R6: A mode fault is raised by an enabled master whose select is low from elsewhere. In hardware mode this means `cfg_drive_en`=0 and the synchronized input is low. In software mode it means `cfg_sw_level`=0. The cycle that sets `mode_fault` also clears `is_master` and `run_en` and releases `sel_pin_oe`.
- R7: `mode_fault` stays set until a one-cycle `fault_clr` pulse, which clears it on the next edge.
- R8: In slave role with hardware select and the controller enabled, `slave_selected` is 1 exactly while the synchronized input is low. In slave role with software select it equals the inverse of `cfg_sw_level`. In master role it is 0.
- R9: In slave role with hardware select, a rise of the synchronized input while `sh_busy` is 1 produces a one-cycle `slave_abort` pulse, one edge after the synchronizer output rises. No pulse occurs when `sh_busy` is 0.
- R10: In auto-release mode the pin is high while idle. On `xfer_req` it goes low, and `xfer_go` rises exactly `HALF_CYC` cycles later.
- R11: In auto-release mode, after `frame_done`, `xfer_go` drops on the next edge and the pin stays low for `HALF_CYC` more cycles. It then goes high for `HALF_CYC`+1 cycles before a pending request pulls it low again. `xfer_go` stays 0 during that time.
- R12: `cfg_wr` loads `cfg_enable` and `cfg_master` into `run_en` and `is_master`. A fault in the same cycle takes priority and leaves both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for enable and role |
| cfg_enable | input | 1 | Controller enable value loaded by `cfg_wr` |
| cfg_master | input | 1 | Master role value loaded by `cfg_wr` |
| cfg_sw_sel | input | 1 | 1: software select, 0: hardware select |
| cfg_sw_level | input | 1 | Internal select level in software mode |
| cfg_drive_en | input | 1 | Drive the select pin as an output when master |
| cfg_auto_rel | input | 1 | Frame each transfer on the select pin |
| fault_clr | input | 1 | Pulse that clears the sticky fault flag |
| xfer_req | input | 1 | Shifter has a master transfer pending |
| frame_done | input | 1 | Last frame of the transfer completed |
| sh_busy | input | 1 | Shifter is inside a slave frame |
| sel_pin_i | input | 1 | Select pin input, asynchronous |
| sel_pin_o | output | 1 | Select pin output value |
| sel_pin_oe | output | 1 | Select pin output enable |
| sel_int | output | 1 | Internal select level |
| xfer_go | output | 1 | Permission for the shifter to clock |
| run_en | output | 1 | Controller enable state |
| is_master | output | 1 | Master role state |
| slave_selected | output | 1 | Slave currently selected |
| slave_abort | output | 1 | One-cycle frame abort pulse |
| mode_fault | output | 1 | Sticky multi-master fault flag |

## Verification
The assertions assume that `frame_done` arrives only while a granted transfer is running, that `sh_busy` is raised only in slave role, and that `fault_clr` is a single-cycle pulse. They also assume the configuration levels change only while the controller is disabled, apart from a deliberate fault trigger. The stimulus keeps to this. It first writes the enable low, then changes the mode levels and the pin, waits out the synchronizer, and only then enables. All inputs change on the falling clock edge, and the pin input is held for several cycles so every synchronizer stage settles.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

   typedef enum logic [2:0] {
      RL_IDLE  = 3'd0,
      RL_LEAD  = 3'd1,
      RL_RUN   = 3'd2,
      RL_TRAIL = 3'd3,
      RL_GAP   = 3'd4
   } rel_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin : chk_stages
      assert (STAGES >= 2) else $fatal(1, "ssel_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= RESET_VAL;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ssel_role.sv
module ssel_role (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_enable,
   input  logic cfg_master,
   input  logic cfg_sw_sel,
   input  logic cfg_sw_level,
   input  logic cfg_drive_en,
   input  logic sel_sync,
   input  logic fault_clr,
   output logic en_q,
   output logic master_q,
   output logic fault_q
);

   logic fault_cond;

   // select seen low while this controller believes it owns the bus
   always_comb begin
      fault_cond = 1'b0;
      if (en_q && master_q) begin
         if (cfg_sw_sel) fault_cond = ~cfg_sw_level;
         else            fault_cond = ~cfg_drive_en & ~sel_sync;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         master_q <= 1'b0;
      end else if (fault_cond) begin
         en_q     <= 1'b0;
         master_q <= 1'b0;
      end else if (cfg_wr) begin
         en_q     <= cfg_enable;
         master_q <= cfg_master;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fault_q <= 1'b0;
      else if (fault_cond) fault_q <= 1'b1;
      else if (fault_clr)  fault_q <= 1'b0;
   end

   // R6: the fault edge coincides with demotion
   assert_demote_on_fault_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> (!master_q && !en_q));

   // R7: flag holds until a clear pulse
   assert_fault_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !fault_clr) |=> fault_q);

   // R6: a fault only arises from an enabled master
   assert_fault_needs_master_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> ($past(master_q) && $past(en_q)));

endmodule

// File: rtl/ssel_release.sv
module ssel_release
   import ssel_pkg::*;
#(
   parameter int unsigned HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic xfer_req,
   input  logic frame_done,
   output logic rel_low,
   output logic rel_go
);

   localparam int unsigned CNT_W = cnt_width(HALF_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

   initial begin : chk_half
      assert (HALF_CYC >= 1) else $fatal(1, "ssel_release: HALF_CYC must be at least 1");
   end

   rel_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RL_IDLE;
         cnt_q <= '0;
      end else if (!active) begin
         st_q  <= RL_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            RL_IDLE: begin
               cnt_q <= '0;
               if (xfer_req) st_q <= RL_LEAD;
            end
            RL_LEAD: begin
               if (cnt_q == CNT_LAST) begin
                  st_q  <= RL_RUN;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RL_RUN: begin
               cnt_q <= '0;
               if (frame_done) st_q <= RL_TRAIL;
            end
            RL_TRAIL: begin
               if (cnt_q == CNT_LAST) begin
                  st_q  <= RL_GAP;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RL_GAP: begin
               if (cnt_q == CNT_LAST) begin
                  st_q  <= RL_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               st_q  <= RL_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign rel_low = (st_q == RL_LEAD) || (st_q == RL_RUN) || (st_q == RL_TRAIL);
   assign rel_go  = (st_q == RL_RUN);

   // R10: the shifter is never released while the select is high
   assert_go_inside_low_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      rel_go |-> rel_low);

   // R11: completion withdraws permission on the next edge
   assert_done_stops_go_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (rel_go && frame_done) |=> !rel_go);

   // R11: a new transfer never starts straight out of the trailing interval
   assert_gap_before_lead_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RL_TRAIL) |=> (st_q != RL_LEAD));

   // R10: counter stays inside its window
   assert_cnt_window_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

endmodule

// File: rtl/ssel_slave.sv
module ssel_slave (
   input  logic clk,
   input  logic rst_n,
   input  logic en_q,
   input  logic master_q,
   input  logic cfg_sw_sel,
   input  logic cfg_sw_level,
   input  logic sel_sync,
   input  logic sh_busy,
   output logic selected,
   output logic abort_q
);

   logic slave_hw;
   logic prev_q;

   assign slave_hw = en_q & ~master_q & ~cfg_sw_sel;
   assign selected = en_q & ~master_q & (cfg_sw_sel ? ~cfg_sw_level : ~sel_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         abort_q <= 1'b0;
      end else begin
         prev_q  <= sel_sync;
         abort_q <= slave_hw & sh_busy & sel_sync & ~prev_q;
      end
   end

   // R9: aborts only come out of a frame in progress
   assert_abort_in_frame_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> $past(sh_busy));

   // R9: the abort is a single-cycle pulse
   assert_abort_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |=> !abort_q);

   // R8: a master never reports itself selected as slave
   assert_no_select_as_master_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      master_q |-> !selected);

endmodule

// File: rtl/ssel_ctrl.sv
module ssel_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HALF_CYC    = 4,
   parameter bit          AUTO_REL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_enable,
   input  logic cfg_master,
   input  logic cfg_sw_sel,
   input  logic cfg_sw_level,
   input  logic cfg_drive_en,
   input  logic cfg_auto_rel,
   input  logic fault_clr,
   input  logic xfer_req,
   input  logic frame_done,
   input  logic sh_busy,
   input  logic sel_pin_i,
   output logic sel_pin_o,
   output logic sel_pin_oe,
   output logic sel_int,
   output logic xfer_go,
   output logic run_en,
   output logic is_master,
   output logic slave_selected,
   output logic slave_abort,
   output logic mode_fault
);

   initial begin : chk_params
      assert (SYNC_STAGES >= 2) else $fatal(1, "ssel_ctrl: SYNC_STAGES below 2");
      assert (HALF_CYC >= 1)    else $fatal(1, "ssel_ctrl: HALF_CYC below 1");
   end

   logic sel_sync;
   logic en_q, master_q, fault_q;
   logic drive_on, auto_on, rel_low, rel_go;

   ssel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sel_pin_i),
      .dout (sel_sync)
   );

   ssel_role u_role (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_enable  (cfg_enable),
      .cfg_master  (cfg_master),
      .cfg_sw_sel  (cfg_sw_sel),
      .cfg_sw_level(cfg_sw_level),
      .cfg_drive_en(cfg_drive_en),
      .sel_sync    (sel_sync),
      .fault_clr   (fault_clr),
      .en_q        (en_q),
      .master_q    (master_q),
      .fault_q     (fault_q)
   );

   ssel_slave u_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_q        (en_q),
      .master_q    (master_q),
      .cfg_sw_sel  (cfg_sw_sel),
      .cfg_sw_level(cfg_sw_level),
      .sel_sync    (sel_sync),
      .sh_busy     (sh_busy),
      .selected    (slave_selected),
      .abort_q     (slave_abort)
   );

   assign drive_on = ~cfg_sw_sel & cfg_drive_en & master_q & en_q;

   generate
      if (AUTO_REL_EN) begin : g_auto
         assign auto_on = drive_on & cfg_auto_rel;
         ssel_release #(.HALF_CYC(HALF_CYC)) u_rel (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (auto_on),
            .xfer_req  (xfer_req),
            .frame_done(frame_done),
            .rel_low   (rel_low),
            .rel_go    (rel_go)
         );
      end else begin : g_fixed
         assign auto_on = 1'b0;
         assign rel_low = 1'b0;
         assign rel_go  = 1'b0;
      end
   endgenerate

   assign sel_pin_oe = drive_on;
   assign sel_pin_o  = ~(drive_on & (auto_on ? rel_low : 1'b1));
   assign sel_int    = cfg_sw_sel ? cfg_sw_level : sel_sync;
   assign xfer_go    = auto_on ? rel_go : (en_q & master_q & xfer_req);
   assign run_en     = en_q;
   assign is_master  = master_q;
   assign mode_fault = fault_q;

   // R6: the pin is released in the cycle the fault is flagged
   assert_oe_released_on_fault_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_fault) |-> !sel_pin_oe);

   // R2: software select never turns the pin into an output
   assert_sw_no_drive_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sw_sel |-> !sel_pin_oe);

   // R3: a driven select without framing is held low
   assert_fixed_low_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pin_oe && !cfg_auto_rel) |-> !sel_pin_o);

endmodule

// File: tb/sim_ssel_ctrl.sv
module sim_ssel_ctrl;

   localparam int unsigned HC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0, cfg_enable = 0, cfg_master = 0, cfg_sw_sel = 0, cfg_sw_level = 1;
   logic cfg_drive_en = 0, cfg_auto_rel = 0, fault_clr = 0;
   logic xfer_req = 0, frame_done = 0, sh_busy = 0, sel_pin_i = 1;
   logic sel_pin_o, sel_pin_oe, sel_int, xfer_go, run_en, is_master;
   logic slave_selected, slave_abort, mode_fault;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ssel_ctrl #(.SYNC_STAGES(2), .HALF_CYC(HC), .AUTO_REL_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
      .cfg_master(cfg_master), .cfg_sw_sel(cfg_sw_sel), .cfg_sw_level(cfg_sw_level),
      .cfg_drive_en(cfg_drive_en), .cfg_auto_rel(cfg_auto_rel), .fault_clr(fault_clr),
      .xfer_req(xfer_req), .frame_done(frame_done), .sh_busy(sh_busy),
      .sel_pin_i(sel_pin_i), .sel_pin_o(sel_pin_o), .sel_pin_oe(sel_pin_oe),
      .sel_int(sel_int), .xfer_go(xfer_go), .run_en(run_en), .is_master(is_master),
      .slave_selected(slave_selected), .slave_abort(slave_abort), .mode_fault(mode_fault)
   );

   // [8]sw_sel [7]sw_level [6]master [5]drive_en [4]pin | [3]oe [2]pin_o [1]sel_int [0]slave_selected
   localparam logic [8:0] TBL [8] = '{
      9'b11111_0110,
      9'b10011_0101,
      9'b11000_0110,
      9'b00111_1010,
      9'b00000_0101,
      9'b00001_0110,
      9'b00101_0110,
      9'b00010_0101
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic setup(input logic sw, input logic lvl, input logic m,
                        input logic de, input logic ar, input logic pin);
      @(negedge clk);
      cfg_enable = 0; cfg_master = 0; cfg_wr = 1;
      @(negedge clk);
      cfg_wr = 0;
      sel_pin_i = pin; cfg_sw_sel = sw; cfg_sw_level = lvl;
      cfg_drive_en = de; cfg_auto_rel = ar;
      repeat (3) @(negedge clk);
      cfg_enable = 1; cfg_master = m; cfg_wr = 1;
      @(negedge clk);
      cfg_wr = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_fault();
      @(negedge clk);
      fault_clr = 1;
      @(negedge clk);
      fault_clr = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int cnt;
      bit seen;
      // ---------------- R1 reset state
      xfer_req = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 run_en", run_en, 0);
      chk("R1 is_master", is_master, 0);
      chk("R1 oe", sel_pin_oe, 0);
      chk("R1 pin_o", sel_pin_o, 1);
      chk("R1 fault", mode_fault, 0);
      chk("R1 abort", slave_abort, 0);
      chk("R1 go", xfer_go, 0);
      xfer_req = 0;

      // ---------------- table of static modes (R2 R4 R8 R3 R12)
      for (int i = 0; i < 8; i++) begin
         setup(TBL[i][8], TBL[i][7], TBL[i][6], TBL[i][5], 1'b0, TBL[i][4]);
         chk($sformatf("R12 run_en row %0d", i), run_en, 1);
         chk($sformatf("R12 role row %0d", i), is_master, TBL[i][6]);
         chk($sformatf("R2/R4 oe row %0d", i), sel_pin_oe, TBL[i][3]);
         chk($sformatf("R3 pin_o row %0d", i), sel_pin_o, TBL[i][2]);
         chk($sformatf("R2/R4 sel_int row %0d", i), sel_int, TBL[i][1]);
         chk($sformatf("R8 selected row %0d", i), slave_selected, TBL[i][0]);
         chk($sformatf("R6 no fault row %0d", i), mode_fault, 0);
      end

      // ---------------- R3 fixed low across a transfer
      setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      xfer_req = 1;
      @(negedge clk);
      chk("R3 go follows req", xfer_go, 1);
      chk("R3 pin low in transfer", sel_pin_o, 0);
      frame_done = 1;
      @(negedge clk);
      frame_done = 0; xfer_req = 0;
      repeat (3) @(negedge clk);
      chk("R3 pin low after transfer", sel_pin_o, 0);
      chk("R3 go drops with req", xfer_go, 0);

      // ---------------- R5 / R8 synchronizer latency in slave role
      setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 not selected while high", slave_selected, 0);
      sel_pin_i = 0;
      @(negedge clk);
      chk("R5 one edge not yet seen", slave_selected, 0);
      @(negedge clk);
      chk("R5 seen after two edges", slave_selected, 1);

      // ---------------- R9 abort
      sh_busy = 1;
      sel_pin_i = 1;
      @(negedge clk);
      chk("R9 abort edge1", slave_abort, 0);
      @(negedge clk);
      chk("R9 abort edge2", slave_abort, 0);
      chk("R8 deselected", slave_selected, 0);
      @(negedge clk);
      chk("R9 abort edge3", slave_abort, 1);
      @(negedge clk);
      chk("R9 abort one cycle", slave_abort, 0);
      sh_busy = 0;
      sel_pin_i = 0;
      repeat (3) @(negedge clk);
      sel_pin_i = 1;
      seen = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (slave_abort) seen = 1;
      end
      chk("R9 no abort when idle", seen, 0);

      // ---------------- R6 / R7 hardware multi-master fault
      setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R6 master before fault", is_master, 1);
      sel_pin_i = 0;
      @(negedge clk);
      @(negedge clk);
      chk("R6 fault not before sync", mode_fault, 0);
      chk("R6 still master", is_master, 1);
      @(negedge clk);
      chk("R6 fault set", mode_fault, 1);
      chk("R6 demoted", is_master, 0);
      chk("R6 disabled", run_en, 0);
      chk("R6 oe released", sel_pin_oe, 0);
      sel_pin_i = 1;
      repeat (5) @(negedge clk);
      chk("R7 fault sticky", mode_fault, 1);
      clear_fault();
      chk("R7 fault cleared", mode_fault, 0);

      // ---------------- R6 / R12 software-mode fault beats cfg_wr
      setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      chk("R12 master loaded", is_master, 1);
      cfg_sw_level = 0; cfg_enable = 1; cfg_master = 1; cfg_wr = 1;
      @(negedge clk);
      cfg_wr = 0;
      chk("R6 sw fault set", mode_fault, 1);
      chk("R12 fault wins role", is_master, 0);
      chk("R12 fault wins enable", run_en, 0);
      cfg_sw_level = 1;
      clear_fault();
      chk("R7 cleared again", mode_fault, 0);

      // ---------------- R10 / R11 auto-release framing
      setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      chk("R10 idle high", sel_pin_o, 1);
      chk("R10 oe on", sel_pin_oe, 1);
      xfer_req = 1;
      cnt = 0;
      while (sel_pin_o && cnt < 20) begin
         @(negedge clk);
         cnt++;
      end
      chk("R10 pin falls on request", cnt, 1);
      cnt = 0;
      while (!xfer_go && !sel_pin_o && cnt < 20) begin
         cnt++;
         @(negedge clk);
      end
      chk("R10 lead cycles", cnt, HC);
      chk("R10 go granted", xfer_go, 1);
      repeat (3) @(negedge clk);
      frame_done = 1;
      @(negedge clk);
      frame_done = 0;
      chk("R11 go dropped", xfer_go, 0);
      cnt = 0;
      while (!sel_pin_o && cnt < 20) begin
         cnt++;
         @(negedge clk);
      end
      chk("R11 trail cycles", cnt, HC);
      cnt = 0;
      seen = 0;
      while (sel_pin_o && cnt < 20) begin
         if (xfer_go) seen = 1;
         cnt++;
         @(negedge clk);
      end
      chk("R11 gap cycles", cnt, HC + 1);
      chk("R11 no go in gap", seen, 0);
      xfer_req = 0;
      setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule